// File: doc/BRIEF.md
# Unaligned Store Beat Splitter

This block sits between a core's store path and a 128-bit memory write port. Each store request carries a 16-bit byte address, one or two data bytes and a stack flag. The block turns the request into one or two aligned 128-bit write beats. Each beat moves the data bytes onto their byte lanes and raises a matching 16-bit byte-enable mask. A two-byte store is split into two beats only when its bytes fall into different 16-byte blocks. Every other store goes out in a single beat.

A word store that has the stack flag set and lies in page one (addresses 0x0100 to 0x01FF) keeps its second byte inside that page. A word at 0x01FF therefore writes its high byte to 0x0100, not to 0x0200. When that wrap places the two bytes in different blocks, the store goes out as two beats and the second beat uses the wrapped address.

Both sides use valid/ready handshakes. The block holds no copy of the request. The write port's valid follows the request's valid, and the request is acknowledged in the same cycle that its final beat is accepted. The requester must hold address, data, size and stack flag steady from the cycle it raises valid until it sees ready. When the write port holds ready low, the block stalls and the current beat stays on the write port unchanged.

Top module: `store_splitter`

## Requirements
- R1: A byte store (`req_size`=0) produces one beat. The beat has `wr_addr` = address with its low 4 bits cleared, the single `wr_be` bit (address mod 16) set, and `req_data[7:0]` on that byte lane (`wr_data` bits 8*lane+7 down to 8*lane). All other lanes are zero.
- R2: A word store (`req_size`=1) whose low-byte offset o is below 15 produces one beat with `wr_be` bits o and o+1 set. `req_data[7:0]` goes on lane o and `req_data[15:8]` on lane o+1.
- R3: A word store at offset 15 produces two beats. The first beat is the low byte's block with `wr_be` bit 15 and the low byte on lane 15. The second beat is the next block with `wr_be` bit 0 and the high byte on lane 0.
- R4: `wr_valid` equals `req_valid`. `req_ready` is high only in a cycle where `wr_ready` is high and the beat on the port is the request's final beat.
- R5: A word store with `req_stack`=1 and address bits [15:8] equal to 0x01 places its high byte at page one's low byte plus one, wrapping mod 256. At 0x01FF this gives two beats, the second at 0x0100 with `wr_be` bit 0.
- R6: The stack wrap applies only when the stack flag is set and the address is in page one. Otherwise the high byte's address is the full 16-bit address plus one, so a word at 0xFFFF gives a second beat at 0x0000.
- R7: While `wr_ready` is low, the beat on the write port and `req_ready` stay unchanged.
- R8: After reset, and after a reset in the middle of a split, the next request starts with its first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Request accepted (final beat taken) |
| req_addr | input | 16 | Byte address of the low byte |
| req_data | input | 16 | [7:0] low byte, [15:8] high byte |
| req_size | input | 1 | 0 = byte, 1 = word |
| req_stack | input | 1 | Store targets the stack |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write port accepts the beat |
| wr_addr | output | 16 | 16-byte aligned beat address |
| wr_data | output | 128 | Beat data, lane i in bits 8i+7:8i |
| wr_be | output | 16 | Per-lane byte enables |

## Verification
The bench aims at offset 15. A splitter that decides the split from the wrong address bits would put both bytes in one beat there and drop or misplace the high byte. The stack page boundary is tested both with the stack flag set and with it clear, and an address just outside page one is also tested. A design that wraps too often would write 0x0100 where 0x0200 belongs, and one that never wraps would corrupt the page above the stack. Stalls held over several cycles and a reset between the two beats of a split check that the second beat never comes out early or twice, and never comes first after reset.

// File: rtl/splt_pkg.sv
package splt_pkg;
  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } store_size_e;
endpackage

// File: rtl/splt_addr_plan.sv
// Works out where the second byte of a store lands and whether the two bytes
// need separate beats.
module splt_addr_plan #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int PAGE_W = 8,
  parameter logic [ADDR_W-PAGE_W-1:0] STACK_PAGE = 1
) (
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic              is_word,
  input  logic              is_stack,
  output logic [ADDR_W-1:0] hi_addr,
  output logic              split
);
  localparam logic [ADDR_W-1:0] ONE_A = 1;
  localparam logic [PAGE_W-1:0] ONE_P = 1;

  logic in_stack_page;
  logic [PAGE_W-1:0] page_off_next;

  always_comb begin
    in_stack_page = is_stack && (lo_addr[ADDR_W-1:PAGE_W] == STACK_PAGE);
    page_off_next = lo_addr[PAGE_W-1:0] + ONE_P;
    if (in_stack_page)
      hi_addr = {lo_addr[ADDR_W-1:PAGE_W], page_off_next};
    else
      hi_addr = lo_addr + ONE_A;
    split = is_word && (lo_addr[ADDR_W-1:OFF_W] != hi_addr[ADDR_W-1:OFF_W]);
  end
endmodule

// File: rtl/splt_lane_pack.sv
// Steers up to two bytes onto their byte lanes and builds the enable mask.
module splt_lane_pack #(
  parameter int LANES = 16,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic               first_en,
  input  logic [OFF_W-1:0]   first_off,
  input  logic [7:0]         first_byte,
  input  logic               second_en,
  input  logic [OFF_W-1:0]   second_off,
  input  logic [7:0]         second_byte,
  output logic [8*LANES-1:0] lane_data,
  output logic [LANES-1:0]   lane_en
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hit_a, hit_b;
    assign hit_a = first_en  && (first_off  == OFF_W'(i));
    assign hit_b = second_en && (second_off == OFF_W'(i));
    assign lane_en[i] = hit_a || hit_b;
    assign lane_data[8*i +: 8] = hit_a ? first_byte :
                                 hit_b ? second_byte : 8'h00;
  end
endmodule

// File: rtl/splt_beat_seq.sv
// Tracks which beat of a split store is on the write port.
module splt_beat_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic split,
  input  logic wr_ready,
  output logic second_beat,
  output logic req_ready
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      phase_q <= 1'b0;
    else if (req_valid && wr_ready) begin
      if (phase_q)
        phase_q <= 1'b0;
      else if (split)
        phase_q <= 1'b1;
    end
  end

  assign second_beat = phase_q;
  assign req_ready   = req_valid && wr_ready && (phase_q || !split);

  // R4: once a request is acknowledged the next beat is a first beat
  assert_ack_resets_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !phase_q);

  // R7: the second beat only appears after the first was taken
  assert_advance_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q) |-> $past(wr_ready) && $past(req_valid));

  // R3: the second beat only exists for a split store
  assert_second_only_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q && req_valid) |-> split);
endmodule

// File: rtl/store_splitter.sv
module store_splitter #(
  parameter int ADDR_W     = 16,
  parameter int LANES      = 16,
  parameter int PAGE_W     = 8,
  parameter int STACK_PAGE = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [15:0]         req_data,
  input  logic                req_size,
  input  logic                req_stack,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [8*LANES-1:0]  wr_data,
  output logic [LANES-1:0]    wr_be
);
  import splt_pkg::*;

  localparam int OFF_W = $clog2(LANES);
  localparam logic [ADDR_W-PAGE_W-1:0] SPAGE = (ADDR_W-PAGE_W)'(STACK_PAGE);

  logic [ADDR_W-1:0] hi_addr;
  logic              split;
  logic              second_beat;
  logic              is_word;
  logic [ADDR_W-1:0] beat_src;

  assign is_word = (store_size_e'(req_size) == SZ_WORD);

  splt_addr_plan #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .STACK_PAGE(SPAGE)
  ) u_plan (
    .lo_addr (req_addr),
    .is_word (is_word),
    .is_stack(req_stack),
    .hi_addr (hi_addr),
    .split   (split)
  );

  splt_beat_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .split      (split),
    .wr_ready   (wr_ready),
    .second_beat(second_beat),
    .req_ready  (req_ready)
  );

  assign beat_src = second_beat ? hi_addr : req_addr;
  assign wr_addr  = {beat_src[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wr_valid = req_valid;

  splt_lane_pack #(.LANES(LANES), .OFF_W(OFF_W)) u_pack (
    .first_en   (!second_beat),
    .first_off  (req_addr[OFF_W-1:0]),
    .first_byte (req_data[7:0]),
    .second_en  (is_word && (second_beat || !split)),
    .second_off (hi_addr[OFF_W-1:0]),
    .second_byte(req_data[15:8]),
    .lane_data  (wr_data),
    .lane_en    (wr_be)
  );

  // R1: every beat is block aligned
  assert_beat_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[OFF_W-1:0] == '0));

  // R2: a beat carries one or two enabled lanes
  assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2));

  // R3: the second beat of a split carries only lane 0
  assert_second_beat_lane0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && second_beat) |-> (wr_be == LANES'(1)));

  // R1: a byte store is acknowledged with its only beat
  assert_byte_single_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_size) |-> (req_ready == wr_ready));

  // R7: a stalled beat is held on the port
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && $stable(req_addr) && $stable(req_data) &&
     $stable(req_size) && $stable(req_stack)) |=> (!wr_valid || $stable(wr_be)));
endmodule

// File: tb/sim_store_splitter.sv
module sim_store_splitter;
  typedef struct packed {
    logic [15:0] addr;
    logic [15:0] data;
    logic        size;
    logic        stack;
    logic        two;
    logic [15:0] a0;
    logic [15:0] be0;
    logic [15:0] a1;
    logic [15:0] be1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{16'h1234, 16'h00AB, 1'b0, 1'b0, 1'b0, 16'h1230, 16'h0010, 16'h0000, 16'h0000}, // R1
    '{16'h0000, 16'h0055, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0001, 16'h0000, 16'h0000}, // R1
    '{16'h01FF, 16'h00C3, 1'b0, 1'b1, 1'b0, 16'h01F0, 16'h8000, 16'h0000, 16'h0000}, // R1 stack byte
    '{16'h2000, 16'hBEEF, 1'b1, 1'b0, 1'b0, 16'h2000, 16'h0003, 16'h0000, 16'h0000}, // R2
    '{16'h200E, 16'h1357, 1'b1, 1'b0, 1'b0, 16'h2000, 16'hC000, 16'h0000, 16'h0000}, // R2
    '{16'h0105, 16'hA1B2, 1'b1, 1'b1, 1'b0, 16'h0100, 16'h0060, 16'h0000, 16'h0000}, // R5
    '{16'h01FE, 16'h7788, 1'b1, 1'b1, 1'b0, 16'h01F0, 16'hC000, 16'h0000, 16'h0000}, // R5
    '{16'h200F, 16'hCAFE, 1'b1, 1'b0, 1'b1, 16'h2000, 16'h8000, 16'h2010, 16'h0001}, // R3
    '{16'h01FF, 16'h4321, 1'b1, 1'b1, 1'b1, 16'h01F0, 16'h8000, 16'h0100, 16'h0001}, // R5
    '{16'h01FF, 16'h9911, 1'b1, 1'b0, 1'b1, 16'h01F0, 16'h8000, 16'h0200, 16'h0001}, // R6
    '{16'h02FF, 16'h6622, 1'b1, 1'b1, 1'b1, 16'h02F0, 16'h8000, 16'h0300, 16'h0001}, // R6
    '{16'hFFFF, 16'hD00D, 1'b1, 1'b0, 1'b1, 16'hFFF0, 16'h8000, 16'h0000, 16'h0001}  // R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [15:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic req_size = 1'b0;
  logic req_stack = 1'b0;
  logic wr_valid;
  logic wr_ready = 1'b0;
  logic [15:0] wr_addr;
  logic [127:0] wr_data;
  logic [15:0] wr_be;

  int n_checks = 0;
  int n_fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  store_splitter u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data),
    .req_size(req_size), .req_stack(req_stack),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fails = n_fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Enabled lanes in ascending order receive b1, then b2.
  function automatic logic [127:0] place(input logic [15:0] be, input logic [7:0] b1,
                                         input logic [7:0] b2);
    logic [127:0] d = '0;
    int k = 0;
    for (int i = 0; i < 16; i++) begin
      if (be[i]) begin
        d[8*i +: 8] = (k == 0) ? b1 : b2;
        k++;
      end
    end
    return d;
  endfunction

  task automatic drive(input vec_t v);
    req_addr = v.addr; req_data = v.data; req_size = v.size; req_stack = v.stack;
    req_valid = 1'b1;
  endtask

  task automatic run_vec(input vec_t v, input int stall);
    logic [7:0] lo, hi, f0b2;
    lo = v.data[7:0];
    hi = v.data[15:8];
    f0b2 = hi;
    @(negedge clk);
    drive(v);
    wr_ready = 1'b0;
    for (int s = 0; s < stall; s++) begin
      #1;
      chk("R7 stall addr", 128'(wr_addr), 128'(v.a0));
      chk("R7 stall ready", 128'(req_ready), 128'(0));
      @(negedge clk);
    end
    wr_ready = 1'b1;
    #1;
    chk("R4 valid", 128'(wr_valid), 128'(1));
    chk(v.two ? "R3 beat0 addr" : "R1/R2 addr", 128'(wr_addr), 128'(v.a0));
    chk(v.two ? "R3 beat0 be" : "R1/R2 be", 128'(wr_be), 128'(v.be0));
    chk(v.two ? "R3 beat0 data" : "R1/R2 data", wr_data, place(v.be0, lo, f0b2));
    chk("R4 ready beat0", 128'(req_ready), 128'(!v.two));
    if (v.two) begin
      @(negedge clk);
      #1;
      chk("R3/R5/R6 beat1 addr", 128'(wr_addr), 128'(v.a1));
      chk("R3 beat1 be", 128'(wr_be), 128'(v.be1));
      chk("R3 beat1 data", wr_data, place(v.be1, hi, 8'h00));
      chk("R4 ready beat1", 128'(req_ready), 128'(1));
    end
    @(negedge clk);
    req_valid = 1'b0;
    wr_ready = 1'b0;
    #1;
    chk("R4 idle valid", 128'(wr_valid), 128'(0));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R8 reset valid", 128'(wr_valid), 128'(0));
    chk("R8 reset ready", 128'(req_ready), 128'(0));
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 0);

    // R7: a split store stalled before each of its beats
    run_vec(VEC[7], 3);
    @(negedge clk);
    drive(VEC[8]);
    wr_ready = 1'b1;
    @(negedge clk);
    wr_ready = 1'b0;
    for (int s = 0; s < 3; s++) begin
      #1;
      chk("R7 held beat1 addr", 128'(wr_addr), 128'(VEC[8].a1));
      chk("R7 held beat1 ready", 128'(req_ready), 128'(0));
      @(negedge clk);
    end
    wr_ready = 1'b1;
    #1;
    chk("R7 released beat1 ready", 128'(req_ready), 128'(1));
    @(negedge clk);
    req_valid = 1'b0;
    wr_ready = 1'b0;

    // R8: reset between the two beats of a split
    @(negedge clk);
    drive(VEC[11]);
    wr_ready = 1'b1;
    @(negedge clk);
    #1;
    chk("R8 pre-reset beat1", 128'(wr_addr), 128'(VEC[11].a1));
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 restart beat0 addr", 128'(wr_addr), 128'(VEC[11].a0));
    chk("R8 restart beat0 be", 128'(wr_be), 128'(VEC[11].be0));
    chk("R8 restart ready", 128'(req_ready), 128'(0));
    @(negedge clk);
    req_valid = 1'b0;
    wr_ready = 1'b0;

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule